// File: doc/BRIEF.md
# Double-Data-Rate I/Q Sample Splitter

This block sits behind a parallel input bus on which in-phase (I) and quadrature (Q) samples arrive in alternation, one word per clock transition. A word is taken on each rising edge and on each falling edge. Each I word is matched with its Q partner, and the pair is sent out on two separate buses, both registered on the rising edge. The block works at one pair per rising clock edge, so the bus carries twice as many words per second as the clock rate. With a 125 MHz clock it carries 250 M words per second.

Three static mode pins set how the words are read. One pin picks which clock edge carries I; the other edge carries Q. A second pin picks whether the I word of a pair comes before or after its Q word. Together these two pins give four timing modes. A third pin says whether the incoming words are two's complement or offset binary. The outputs are always two's complement. The sample width is a parameter, and the supported values are 8, 10, 12 and 14.

The output stream is a valid-only stream with no ready input. The bus source cannot pause, so no back-pressure is possible. A consumer must accept every cycle on which `pair_valid` is high. After a reset, and after any change on a mode pin, `pair_valid` stays low until a pair captured wholly under the new settings reaches the outputs.

Top module: `ddr_iq_splitter`

## Requirements
- R1: A word is captured from `bus_data` on every rising and every falling edge of `clk`, and no captured word is lost or duplicated in steady state.
- R2: When `rise_is_i` equals `i_leads`, a pair is the word from rising edge k together with the word from the falling edge that follows it.
- R3: When `rise_is_i` differs from `i_leads`, a pair is the word from the falling edge just before rising edge k together with the word from rising edge k.
- R4: With `rise_is_i`=1 the rising-edge word of each pair appears on `i_out` and the falling-edge word on `q_out`; with `rise_is_i`=0 the routing is swapped.
- R5: With `in_twos`=1 the output words equal the captured words bit for bit.
- R6: With `in_twos`=0 each output word is the captured word with its most significant bit (bit DW-1) inverted, and all other bits are unchanged.
- R7: A pair appears on the outputs right after the second rising edge that follows the capture of the later of its two words. This holds in all four modes. Pairs that include rising edge k appear after rising edge k+2.
- R8: In steady state, with the mode pins unchanged, `pair_valid` is high after every rising edge, giving one pair per clock cycle.
- R9: While `rst_n` is low, `pair_valid`, `i_out` and `q_out` are zero. `pair_valid` first rises after the fourth rising edge following release.
- R10: The mode pins are sampled on rising edges. If their value at edge t differs from their value at edge t-1, `pair_valid` is low after edges t, t+1 and t+2, and high again after edge t+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus qualifying clock; both edges capture data |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | DW | Interleaved I/Q word bus, one word per edge |
| rise_is_i | input | 1 | 1: rising-edge words are I; 0: they are Q |
| i_leads | input | 1 | 1: I word precedes its Q word; 0: it follows |
| in_twos | input | 1 | 1: input is two's complement; 0: offset binary |
| i_out | output | DW | In-phase sample, two's complement |
| q_out | output | DW | Quadrature sample, two's complement |
| pair_valid | output | 1 | High for each rising edge that delivers a pair |

## Verification
On every cycle the assertions check four things: the hold-off that follows each mode change, the unbroken run of `pair_valid` in steady state, the quiet outputs right after reset, and the rising-edge word arriving on the selected channel with the selected MSB treatment three sampling edges later. The falling-edge half of each pair, and how pairs form in the two orderings, can only be shown by the bench's scenarios. The bench drives a unique word on every edge and computes, for each of the eight pin combinations, the exact words expected on both buses. It also covers a mid-stream reset and a one-cycle mode glitch.

// File: rtl/iqs_pkg.sv
package iqs_pkg;
  typedef struct packed {
    logic rise_is_i;
    logic i_leads;
    logic in_twos;
  } iqs_mode_t;
endpackage

// File: rtl/iqs_capture.sv
module iqs_capture #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_data,
  output logic [DW-1:0] rise_now,
  output logic [DW-1:0] rise_prev,
  output logic [DW-1:0] fall_prev
);
  logic [DW-1:0] neg_hold;

  // falling-edge word parked until the next rising edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_hold <= '0;
    else        neg_hold <= bus_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_now  <= '0;
      rise_prev <= '0;
      fall_prev <= '0;
    end else begin
      rise_now  <= bus_data;
      rise_prev <= rise_now;
      fall_prev <= neg_hold;
    end
  end
endmodule

// File: rtl/iqs_align.sv
module iqs_align #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_first,
  input  logic [DW-1:0] rise_now,
  input  logic [DW-1:0] rise_prev,
  input  logic [DW-1:0] fall_prev,
  output logic [DW-1:0] pair_rise,
  output logic [DW-1:0] pair_fall
);
  logic [DW-1:0] mid_rise, mid_fall;

  // falling-first pairs complete one edge earlier: delay them to match
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_rise <= '0;
      mid_fall <= '0;
    end else begin
      mid_rise <= rise_now;
      mid_fall <= fall_prev;
    end
  end

  always_comb begin
    if (rise_first) begin
      pair_rise = rise_prev;
      pair_fall = fall_prev;
    end else begin
      pair_rise = mid_rise;
      pair_fall = mid_fall;
    end
  end
endmodule

// File: rtl/iqs_emit.sv
module iqs_emit #(
  parameter int DW = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  iqs_pkg::iqs_mode_t mode_in,
  input  logic [DW-1:0]     pair_rise,
  input  logic [DW-1:0]     pair_fall,
  output iqs_pkg::iqs_mode_t mode_q,
  output logic [DW-1:0]     i_out,
  output logic [DW-1:0]     q_out,
  output logic              pair_valid
);
  localparam logic [DW-1:0] MSB_MASK = {1'b1, {(DW-1){1'b0}}};
  localparam logic [1:0]    HOLD_RST = 2'd3;
  localparam logic [1:0]    HOLD_CHG = 2'd2;

  logic          chg;
  logic [1:0]    hold;
  logic [DW-1:0] flip, i_next, q_next;

  assign chg    = (mode_in != mode_q);
  assign flip   = mode_q.in_twos ? '0 : MSB_MASK;
  assign i_next = (mode_q.rise_is_i ? pair_rise : pair_fall) ^ flip;
  assign q_next = (mode_q.rise_is_i ? pair_fall : pair_rise) ^ flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      hold       <= HOLD_RST;
      pair_valid <= 1'b0;
      i_out      <= '0;
      q_out      <= '0;
    end else begin
      mode_q     <= mode_in;
      pair_valid <= !chg && (hold == 2'd0);
      if (chg)               hold <= HOLD_CHG;
      else if (hold != 2'd0) hold <= hold - 2'd1;
      i_out <= i_next;
      q_out <= q_next;
    end
  end
endmodule

// File: rtl/ddr_iq_splitter.sv
module ddr_iq_splitter #(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_data,
  input  logic          rise_is_i,
  input  logic          i_leads,
  input  logic          in_twos,
  output logic [DW-1:0] i_out,
  output logic [DW-1:0] q_out,
  output logic          pair_valid
);
  iqs_pkg::iqs_mode_t mode_in, mode_q;
  logic [DW-1:0] rise_now, rise_prev, fall_prev, pair_rise, pair_fall;
  logic          rise_first;

  assign mode_in    = '{rise_is_i: rise_is_i, i_leads: i_leads, in_twos: in_twos};
  assign rise_first = (mode_q.rise_is_i == mode_q.i_leads);

  iqs_capture #(.DW(DW)) cap_i (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data),
    .rise_now(rise_now), .rise_prev(rise_prev), .fall_prev(fall_prev)
  );

  iqs_align #(.DW(DW)) aln_i (
    .clk(clk), .rst_n(rst_n), .rise_first(rise_first),
    .rise_now(rise_now), .rise_prev(rise_prev), .fall_prev(fall_prev),
    .pair_rise(pair_rise), .pair_fall(pair_fall)
  );

  iqs_emit #(.DW(DW)) emt_i (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in),
    .pair_rise(pair_rise), .pair_fall(pair_fall), .mode_q(mode_q),
    .i_out(i_out), .q_out(q_out), .pair_valid(pair_valid)
  );
endmodule

// File: rtl/ddr_iq_splitter_chk.sv
module ddr_iq_splitter_chk #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] bus_data,
  input logic          rise_is_i,
  input logic          i_leads,
  input logic          in_twos,
  input logic [DW-1:0] i_out,
  input logic [DW-1:0] q_out,
  input logic          pair_valid
);
  logic [2:0]    mode_v;
  logic [DW-1:0] msb_one;
  assign mode_v  = {rise_is_i, i_leads, in_twos};
  assign msb_one = {1'b1, {(DW-1){1'b0}}};

  assert_holdoff_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_v != $past(mode_v)) |=> !pair_valid ##1 !pair_valid);

  assert_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && (mode_v == $past(mode_v))) |=> pair_valid);

  assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pair_valid && i_out == '0 && q_out == '0));

  // rising-edge word, taken three sampling edges earlier, on its channel
  assert_rise_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (($past(mode_v[2]) ? i_out : q_out) ==
                    ($past(bus_data, 3) ^ ($past(mode_v[0]) ? '0 : msb_one))));
endmodule

bind ddr_iq_splitter ddr_iq_splitter_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .rise_is_i(rise_is_i),
  .i_leads(i_leads), .in_twos(in_twos), .i_out(i_out), .q_out(q_out),
  .pair_valid(pair_valid)
);

// File: tb/ddr_iq_splitter_tb_top.sv
`timescale 1ns/1ps
module ddr_iq_splitter_tb_top;
  localparam int DW = 14;
  localparam logic [DW-1:0] MSB1 = {1'b1, {(DW-1){1'b0}}};
  // {rise_is_i, i_leads, in_twos, cycles to run}
  localparam logic [7:0] VEC [8] = '{
    {3'b100, 5'd10}, {3'b110, 5'd10}, {3'b010, 5'd10}, {3'b000, 5'd10},
    {3'b001, 5'd10}, {3'b011, 5'd10}, {3'b111, 5'd10}, {3'b101, 5'd10}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic rise_is_i = 1'b0, i_leads = 1'b0, in_twos = 1'b0;
  logic [DW-1:0] bus_data, i_out, q_out;
  logic pair_valid;
  int cyc = 0, c_mark = 0, tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_iq_splitter #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .rise_is_i(rise_is_i),
    .i_leads(i_leads), .in_twos(in_twos), .i_out(i_out), .q_out(q_out),
    .pair_valid(pair_valid));

  // word on edge e: even e = rising edge e/2, odd e = falling edge after it
  function automatic logic [DW-1:0] wordf(int e);
    logic [31:0] v;
    v = 32'(e * 97 + 13);
    return v[DW-1:0];
  endfunction

  initial begin
    bus_data = wordf(2);
    forever begin
      @(posedge clk); #1;
      bus_data = wordf(2 * cyc + 1);
      @(negedge clk); #1;
      bus_data = wordf(2 * (cyc + 1));
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic check_cycle();
    int m = cyc;
    bit exp_v = (m >= c_mark + 4);
    bit rfirst = (rise_is_i == i_leads);
    logic [DW-1:0] r, f, flip, ei, eq;
    chk(pair_valid == exp_v, "R8 R10 valid", 32'(pair_valid), 32'(exp_v));
    if (exp_v) begin
      r = wordf(2 * (m - 2));                                  // R7 latency
      f = rfirst ? wordf(2 * (m - 2) + 1) : wordf(2 * (m - 3) + 1); // R2 / R3
      flip = in_twos ? '0 : MSB1;                              // R5 / R6
      ei = (rise_is_i ? r : f) ^ flip;                         // R4 routing
      eq = (rise_is_i ? f : r) ^ flip;
      chk(i_out == ei && q_out == eq,
          rfirst ? "R1 R2 R4 R5 R6 R7 pair" : "R1 R3 R4 R5 R6 R7 pair",
          {i_out, q_out}, {ei, eq});
    end
  endtask

  task automatic set_mode(logic [2:0] mv);
    if (mv != {rise_is_i, i_leads, in_twos}) c_mark = cyc;
    {rise_is_i, i_leads, in_twos} = mv;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(pair_valid == 1'b0 && i_out == '0 && q_out == '0, "R9 reset",
        {i_out, q_out, 1'b0, pair_valid}, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    c_mark = cyc;
    for (int k = 0; k < 8; k++) begin
      set_mode(VEC[k][7:5]);
      for (int n = 0; n < int'(VEC[k][4:0]); n++) begin
        @(posedge clk); #1;
        check_cycle();
      end
    end
    // mid-stream reset: outputs clear at once, then the R9 start-up count
    @(posedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    chk(pair_valid == 1'b0 && i_out == '0 && q_out == '0, "R9 async reset",
        {i_out, q_out, 1'b0, pair_valid}, 32'd0);
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    c_mark = cyc;
    for (int n = 0; n < 7; n++) begin
      @(posedge clk); #1;
      check_cycle();
    end
    // one-cycle glitch on a mode pin: hold-off restarts from the second change (R10)
    set_mode({rise_is_i, i_leads, ~in_twos});
    @(posedge clk); #1;
    check_cycle();
    set_mode({rise_is_i, i_leads, ~in_twos});
    for (int n = 0; n < 7; n++) begin
      @(posedge clk); #1;
      check_cycle();
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d actual running expected done", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule